// File: doc/BRIEF.md
# Link-On Indication Controller

This block owns one bidirectional pin of a serial-bus physical layer that serves two purposes. While hardware reset is held, the pin is an input: an external resistor pulls it high or low, and the block captures that level as the default contender flag. A high strap marks the node as capable of acting as bus manager. This flag is later reported during self-identification.

When reset is released, the pin becomes an output for good. From then on it wakes a powered-down link layer. While the link reports its power status as inactive, certain wake events make the block drive a square wave of about 6.1 MHz on the pin. The wave is made by dividing a 49.152 MHz reference clock by eight.

The block keeps a separate record of each cause. One cause is a link-on packet addressed to this node. The other is an event in the status register. A bus reset withdraws the wave only when a packet was the sole reason for it. The link power status is asynchronous and is synchronized before use. A register event that is still asserted while the link is powered arms the wave as soon as link power drops.

Top module: `lkon_ctrl`

## Requirements
- R1: While `rst_ni` is low, `contender_o` follows the level on `pad_i` one clock later (1 = bus-manager capable, 0 = not capable).
- R2: `pad_oe_o` is 0 during reset and becomes 1 at the first clock edge with `rst_ni` high, then stays 1. From that edge on, `contender_o` keeps the last strapped value.
- R3: The active wave has a period of 8 reference clocks: 4 cycles low followed by 4 cycles high. After the edge that activates it, the wave always starts with its low half.
- R4: The wave is triggered by any of these with link power inactive: a `lkon_pkt_i` pulse, `port_evt_i` = 1, or any of `timeout_i`/`pwr_fail_i`/`loop_i` = 1 together with `resume_int_i` = 1. Any of the last three without `resume_int_i` triggers nothing.
- R5: Once raised, the wave persists even after the triggering input falls. It stops, with the pin held low, two clocks after `lps_i` rises: the synchronizer takes two clocks and is the only delay. Both causes are cleared at that point.
- R6: A `bus_rst_i` pulse stops the wave at the next edge if the only cause was a link-on packet. If a register event is recorded, the wave continues without a phase break.
- R7: A register event held while link power is active produces no wave. The wave then starts at the third edge after `lps_i` falls. A link-on packet received while link power is active is discarded.
- R8: A link-on packet and a bus reset in the same cycle leave the packet cause set; the packet wins.
- R9: With no recorded cause, `pad_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (49.152 MHz nominal) |
| rst_ni | input | 1 | Hardware reset, active low, sampled synchronously |
| pad_i | input | 1 | Level read back from the shared pin (strap during reset) |
| pad_o | output | 1 | Wake wave driven onto the pin |
| pad_oe_o | output | 1 | Pin output enable |
| contender_o | output | 1 | Strapped default contender flag |
| lkon_pkt_i | input | 1 | One-cycle pulse: link-on packet for this node received |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset occurred |
| port_evt_i | input | 1 | Port-event status bit |
| timeout_i | input | 1 | Timeout status bit |
| pwr_fail_i | input | 1 | Power-fail status bit |
| loop_i | input | 1 | Loop-detected status bit |
| resume_int_i | input | 1 | Resume-interrupt enable bit |
| lps_i | input | 1 | Link power status, asynchronous, 1 = link active |

## Verification
Two functions can fall in the same cycle: setting the packet cause and clearing it on a bus reset. The bench pulses `lkon_pkt_i` and `bus_rst_i` on the same edge while the pin is idle. It then expects the wave to start in its low phase and run a full period. A second collision pits a bus reset against a recorded register event. There the wave must run on without a phase break. Each case is judged cycle by cycle against an 8-cycle pattern that the bench computes from the activation edge.

// File: rtl/lkon_pkg.sv
package lkon_pkg;

    // Recorded reasons for the wake wave
    typedef struct packed {
        logic pkt;   // raised by a link-on packet
        logic regv;  // raised by a status-register event
    } cause_t;

    // Top-level registered state
    typedef struct packed {
        logic oe;
        logic contender;
    } pin_state_t;

endpackage

// File: rtl/lkon_sync.sv
module lkon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        if (!rst_ni) begin
            sh_d = '0;
        end else begin
            sh_d = {sh_q[STAGES-2:0], d_i};
        end
    end

    always_ff @(posedge clk_i) begin
        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lkon_cause.sv
module lkon_cause
    import lkon_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   lps_s_i,
    input  logic   pkt_i,
    input  logic   bus_rst_i,
    input  logic   reg_evt_i,
    output cause_t cause_o
);
    cause_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!rst_ni || lps_s_i) begin
            // link powered: nothing may be recorded, pending flags drop
            c_d = '0;
        end else begin
            if (reg_evt_i) begin
                c_d.regv = 1'b1;
            end
            // a fresh packet outranks a bus reset in the same cycle
            if (pkt_i) begin
                c_d.pkt = 1'b1;
            end else if (bus_rst_i) begin
                c_d.pkt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        c_q <= c_d;
    end

    assign cause_o = c_q;
endmodule

// File: rtl/lkon_div.sv
module lkon_div #(
    parameter int unsigned DIV_LOG2 = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic wave_o
);
    logic [DIV_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!rst_ni || !run_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign wave_o = run_i & cnt_q[DIV_LOG2-1];
endmodule

// File: rtl/lkon_ctrl.sv
module lkon_ctrl
    import lkon_pkg::*;
#(
    parameter int unsigned DIV_LOG2    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pad_i,
    output logic pad_o,
    output logic pad_oe_o,
    output logic contender_o,
    input  logic lkon_pkt_i,
    input  logic bus_rst_i,
    input  logic port_evt_i,
    input  logic timeout_i,
    input  logic pwr_fail_i,
    input  logic loop_i,
    input  logic resume_int_i,
    input  logic lps_i
);
    pin_state_t st_d, st_q;
    cause_t     cause;
    logic       lps_s;
    logic       reg_evt;
    logic       run;

    lkon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (lps_i),
        .q_o   (lps_s)
    );

    assign reg_evt = port_evt_i | ((timeout_i | pwr_fail_i | loop_i) & resume_int_i);

    lkon_cause u_cause (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lps_s_i  (lps_s),
        .pkt_i    (lkon_pkt_i),
        .bus_rst_i(bus_rst_i),
        .reg_evt_i(reg_evt),
        .cause_o  (cause)
    );

    assign run = (cause.pkt | cause.regv) & ~lps_s;

    lkon_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .wave_o(pad_o)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_ni) begin
            st_d.oe        = 1'b0;
            st_d.contender = pad_i;
        end else begin
            st_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pad_oe_o    = st_q.oe;
    assign contender_o = st_q.contender;
endmodule

// File: rtl/lkon_ctrl_chk.sv
module lkon_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic pad_o,
    input logic pad_oe_o,
    input logic contender_o,
    input logic lkon_pkt_i,
    input logic bus_rst_i,
    input logic lps_s,
    input logic cause_pkt,
    input logic cause_regv
);
    // R2
    oe_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pad_oe_o);

    // R2
    contender_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(contender_o));

    // R3
    low_half_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pad_o) |-> (!$past(pad_o, 2) && !$past(pad_o, 4)));

    // R5
    quiet_when_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lps_s |-> !pad_o);

    // R6
    bus_reset_clears_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rst_i && !lkon_pkt_i) |=> !cause_pkt);

    // R8
    pkt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lkon_pkt_i && !lps_s) |=> cause_pkt);

    // R9
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cause_pkt || cause_regv) |-> !pad_o);
endmodule

bind lkon_ctrl lkon_ctrl_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o),
    .contender_o(contender_o),
    .lkon_pkt_i (lkon_pkt_i),
    .bus_rst_i  (bus_rst_i),
    .lps_s      (lps_s),
    .cause_pkt  (cause.pkt),
    .cause_regv (cause.regv)
);

// File: tb/lkon_ctrl_tb.sv
`timescale 1ns/100ps
module lkon_ctrl_tb_top;

    localparam int SEL_PAD = 0;
    localparam int SEL_OE  = 1;
    localparam int SEL_CON = 2;

    typedef struct {
        int    sel;
        logic  exp;
        string tag;
    } item_t;

    logic clk_i = 1'b0;
    logic rst_ni, pad_i, pad_o, pad_oe_o, contender_o;
    logic lkon_pkt_i, bus_rst_i, port_evt_i, timeout_i, pwr_fail_i, loop_i, resume_int_i, lps_i;

    int    checks   = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];

    lkon_ctrl dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pad_i       (pad_i),
        .pad_o       (pad_o),
        .pad_oe_o    (pad_oe_o),
        .contender_o (contender_o),
        .lkon_pkt_i  (lkon_pkt_i),
        .bus_rst_i   (bus_rst_i),
        .port_evt_i  (port_evt_i),
        .timeout_i   (timeout_i),
        .pwr_fail_i  (pwr_fail_i),
        .loop_i      (loop_i),
        .resume_int_i(resume_int_i),
        .lps_i       (lps_i)
    );

    always #2.5 clk_i = ~clk_i;

    // expected wave level k edges after activation (k = 1 is the activating edge)
    function automatic logic wave(input int k);
        return ((k - 1) % 8) >= 4;
    endfunction

    task automatic push(input int sel, input logic exp, input string tag);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // expectation for the coming edge, then advance to the next falling edge
    task automatic tick(input logic ep, input string tag);
        push(SEL_PAD, ep, tag);
        @(negedge clk_i);
    endtask

    task automatic wave_run(input int k0, input int k1, input string tag);
        for (int k = k0; k <= k1; k++) begin
            tick(wave(k), tag);
        end
    endtask

    task automatic idle_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick(1'b0, tag);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // monitor: compare every queued item one time unit after the edge
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic  act;
                it = sb_q.pop_front();
                case (it.sel)
                    SEL_OE:  act = pad_oe_o;
                    SEL_CON: act = contender_o;
                    default: act = pad_o;
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b at %0t",
                             it.tag, it.sel, act, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        rst_ni = 1'b0; pad_i = 1'b1;
        lkon_pkt_i = 1'b0; bus_rst_i = 1'b0; port_evt_i = 1'b0; timeout_i = 1'b0;
        pwr_fail_i = 1'b0; loop_i = 1'b0; resume_int_i = 1'b0; lps_i = 1'b0;

        // R1 strap sampling during reset, R2 output enable off
        push(SEL_OE, 1'b0, "R2"); push(SEL_CON, 1'b1, "R1"); tick(1'b0, "R9");
        pad_i = 1'b0; push(SEL_CON, 1'b0, "R1"); tick(1'b0, "R9");
        pad_i = 1'b1; push(SEL_CON, 1'b1, "R1"); push(SEL_OE, 1'b0, "R2"); tick(1'b0, "R9");
        // R2 release: pin turns output, strap frozen
        rst_ni = 1'b1; pad_i = 1'b0;
        push(SEL_OE, 1'b1, "R2"); push(SEL_CON, 1'b1, "R2"); tick(1'b0, "R9");
        for (int i = 0; i < 4; i++) begin
            pad_i = ~pad_i;
            push(SEL_CON, 1'b1, "R2");
            push(SEL_OE, 1'b1, "R2");
            tick(1'b0, "R9");
        end

        // R3 packet-triggered wave, low half first, period 8
        lkon_pkt_i = 1'b1; tick(wave(1), "R3"); lkon_pkt_i = 1'b0;
        wave_run(2, 20, "R3");
        // R6 bus reset cancels a packet-only wave
        bus_rst_i = 1'b1; tick(1'b0, "R6"); bus_rst_i = 1'b0;
        idle_run(5, "R6");

        // R4 port event; R6 bus reset does not cancel a register cause
        port_evt_i = 1'b1; tick(wave(1), "R4"); port_evt_i = 1'b0;
        wave_run(2, 10, "R4");
        bus_rst_i = 1'b1; tick(wave(11), "R6"); bus_rst_i = 0;
        wave_run(12, 14, "R6");
        // R5 stops two edges after link power rises
        lps_i = 1'b1; tick(wave(15), "R5"); tick(1'b0, "R5");
        idle_run(4, "R5");

        // R7 packet while powered is discarded
        lkon_pkt_i = 1'b1; tick(1'b0, "R7"); lkon_pkt_i = 1'b0; tick(1'b0, "R7");
        lps_i = 1'b0; idle_run(6, "R7");
        // R7 pending register event re-arms when power drops
        lps_i = 1'b1; idle_run(3, "R7");
        timeout_i = 1'b1; resume_int_i = 1'b1; idle_run(3, "R7");
        lps_i = 1'b0; tick(1'b0, "R7"); tick(1'b0, "R7");
        wave_run(1, 12, "R7");
        lps_i = 1'b1; timeout_i = 1'b0; resume_int_i = 1'b0;
        tick(wave(13), "R5"); tick(1'b0, "R5"); idle_run(3, "R5");
        lps_i = 1'b0; idle_run(4, "R5");

        // R4 error bits need the resume enable
        loop_i = 1'b1; idle_run(4, "R4");
        pwr_fail_i = 1'b1; idle_run(3, "R4");
        resume_int_i = 1'b1; tick(wave(1), "R4");
        wave_run(2, 9, "R4");
        lps_i = 1'b1; loop_i = 1'b0; pwr_fail_i = 1'b0; resume_int_i = 1'b0;
        tick(wave(10), "R5"); tick(1'b0, "R5"); idle_run(3, "R5");
        lps_i = 1'b0; idle_run(4, "R9");

        // R8 packet and bus reset in one cycle: packet wins
        lkon_pkt_i = 1'b1; bus_rst_i = 1'b1; tick(wave(1), "R8");
        lkon_pkt_i = 1'b0; bus_rst_i = 1'b0;
        wave_run(2, 9, "R8");
        bus_rst_i = 1'b1; tick(1'b0, "R6"); bus_rst_i = 1'b0;
        idle_run(3, "R9");

        @(posedge clk_i);
        #2;
        finished = 1'b1;
        report();
    end
endmodule